// File: doc/BRIEF.md
# Tick Timer with Prescaler

An 8-bit counting register that advances on one of two tick sources: a one-cycle enable from the processor's instruction clock, or edges seen on an external clock pin. An option register picks the source, which edge of the pin counts, and whether a power-of-two prescaler sits between the source and the counter. Software reads and writes the count, the options and a sticky overflow flag over a small single-cycle register bus.

The external pin is asynchronous. It passes through a two-stage synchronizer and a history flop before edge detection. Any bus write to the count restarts the prescaler. Each count wrap from all ones to zero sets the overflow flag. The flag also drives an output pin that an interrupt controller can sample.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 00h, the overflow flag reads 0 and `ovf_o` is low, and the option register reads FFh.
- R2: The count is read and written at address 01h. The option register is at address 08h. The flag register is at address 0Bh, with the flag in bit 0 and zeros in bits 7:1.
- R3: With option bit 5 at 0, the tick source is `cyc_tick_i`. With option bit 3 at 1, the prescaler is bypassed and the count rises by one on every clock with `cyc_tick_i` high.
- R4: With option bit 5 at 1 and option bit 4 at 0, each rising edge of `ext_clk_i` adds one to the count. Falling edges of the pin add nothing, and `cyc_tick_i` is ignored.
- R5: With option bit 5 at 1 and option bit 4 at 1, each falling edge of `ext_clk_i` adds one to the count. Rising edges of the pin add nothing.
- R6: With option bit 3 at 0, the count rises once per 2^(n+1) source ticks, where n is option bits 2:0.
- R7: While the prescaler is in use (bit 3 at 0), a write to the count also restarts the prescaler from zero.
- R8: When a source increment takes the count from FFh to 00h, the flag is set. It stays set until software writes 0 to bit 0 of the flag register.
- R9: When a count write and an increment fall in the same cycle, the written value is stored and the increment is lost.
- R10: A pin edge reaches the count on the third rising clock edge after the pin changes. Two of those clocks are synchronizer stages and one is the edge history flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_tick_i | input | 1 | Instruction-cycle tick enable |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The prescaler's internal phase cannot be read from the ports, so the restart on a count write is hard to observe. The stimulus first sets a 1:8 ratio and feeds five ticks, which leaves the prescaler mid-cycle. It then writes the count and feeds seven more ticks. The count holds through those seven ticks only if the prescaler really restarted, and it moves on the eighth. The collision of a bus write with an increment is driven by raising the tick enable in the same cycle as the write strobe.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_COUNT = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_OPT   = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 8'h0B;

  localparam int unsigned OPT_SRC  = 5;  // 1: external pin
  localparam int unsigned OPT_EDGE = 4;  // 1: falling edge
  localparam int unsigned OPT_BYP  = 3;  // 1: prescaler bypassed
  localparam int unsigned RATIO_W  = 3;  // ratio field at [2:0]
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;  // [STAGES-1] synchronized, [STAGES] history
  logic cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign cur    = sh_q[STAGES-1];
  assign prev   = sh_q[STAGES];
  assign edge_o = fall_sel_i ? (prev & ~cur) : (cur & ~prev);

  // a rising edge cannot repeat on the next clock
  p_single_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && !fall_sel_i) |=> !(edge_o && !fall_sel_i));
  p_single_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && fall_sel_i) |=> !(edge_o && fall_sel_i));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W    = 8,
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               use_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               clear_i,
  output logic               inc_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;
  logic            hit;

  always_comb begin
    for (int i = 0; i < PS_W; i++) mask[i] = (i <= int'(ratio_i));
  end

  assign hit   = (cnt_q & mask) == mask;
  assign inc_o = use_i ? (tick_i & hit) : tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (use_i && clear_i)  cnt_q <= '0;
    else if (use_i && tick_i)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && clear_i) |=> (cnt_q == '0));
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && inc_o) |=> (cnt_q == '0));
  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_cnt_i,
  input  logic              wr_flag_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              ovf_q;
  logic              wrap;

  assign wrap = inc_i && !wr_cnt_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= wdata_i;  // write beats increment
    else if (inc_i)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;    // a wrap is never lost to a clear
    else if (wr_flag_i) ovf_q <= wdata_i[0];
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_q == $past(wdata_i)));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && inc_i) |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && !inc_i) |=> $stable(cnt_q));
  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_cnt_i && cnt_q == '1) |=> ovf_q);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !wr_flag_i) |=> ovf_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PS_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_tick_i,
  input  logic              ext_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] opt_q;
  logic [DATA_W-1:0] cnt;
  logic              ovf;
  logic              pin_edge, src_tick, inc;
  logic              wr_cnt, wr_opt, wr_flag;

  assign wr_cnt  = wr_en_i && (addr_i == ADDR_COUNT);
  assign wr_opt  = wr_en_i && (addr_i == ADDR_OPT);
  assign wr_flag = wr_en_i && (addr_i == ADDR_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     opt_q <= '1;
    else if (wr_opt) opt_q <= wdata_i;
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_clk_i),
    .fall_sel_i (opt_q[OPT_EDGE]),
    .edge_o     (pin_edge)
  );

  assign src_tick = opt_q[OPT_SRC] ? pin_edge : cyc_tick_i;

  tmr_prescaler #(.PS_W(PS_W), .RATIO_W(RATIO_W)) u_ps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (src_tick),
    .use_i   (!opt_q[OPT_BYP]),
    .ratio_i (opt_q[RATIO_W-1:0]),
    .clear_i (wr_cnt),
    .inc_o   (inc)
  );

  tmr_core #(.DATA_W(DATA_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .wr_cnt_i  (wr_cnt),
    .wr_flag_i (wr_flag),
    .wdata_i   (wdata_i),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_COUNT: rdata_o = cnt;
      ADDR_OPT:   rdata_o = opt_q;
      ADDR_FLAG:  rdata_o = {{(DATA_W-1){1'b0}}, ovf};
      default:    rdata_o = '0;
    endcase
  end

  assign ovf_o = ovf;

  // with the pin selected, the instruction tick never moves the count
  p_pin_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_q[OPT_SRC] && !pin_edge && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       ovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // scoreboard: kind 0 = rdata_o, kind 1 = ovf_o
  int         kind_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  tick_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_tick_i(cyc_tick_i),
    .ext_clk_i(ext_clk_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ovf_o(ovf_o)
  );

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk_i) begin
    #2;
    while (exp_q.size() > 0) begin
      automatic int         k = kind_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      automatic logic [7:0] a = (k == 0) ? rdata_o : {7'b0, ovf_o};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic expect_item(input int k, input logic [7:0] e, input string t);
    kind_q.push_back(k);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk_i);
    addr_i = a;
    expect_item(0, e, t);
    @(negedge clk_i);
  endtask

  task automatic ovf_chk(input logic e, input string t);
    @(negedge clk_i);
    expect_item(1, {7'b0, e}, t);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    cyc_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cyc_tick_i = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); ext_clk_i = 1'b1;
      repeat (3) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    read_chk(8'h01, 8'h00, "R1 count");
    read_chk(8'h08, 8'hFF, "R1 option");
    read_chk(8'h0B, 8'h00, "R1 flag");
    ovf_chk(1'b0, "R1 ovf_o");

    // R2 register access
    wr(8'h01, 8'h5A);
    read_chk(8'h01, 8'h5A, "R2 count rw");
    wr(8'h08, 8'h08);
    read_chk(8'h08, 8'h08, "R2 option rw");

    // R3 internal, bypass
    wr(8'h01, 8'h00);
    ticks(10);
    read_chk(8'h01, 8'h0A, "R3 ten ticks");

    // R4 rising edges, instruction tick ignored
    wr(8'h08, 8'h28);
    wr(8'h01, 8'h00);
    cyc_tick_i = 1'b1;
    pulses(4);
    cyc_tick_i = 1'b0;
    read_chk(8'h01, 8'h04, "R4 rising edges");

    // R10 latency, rising mode
    wr(8'h01, 8'h00);
    @(negedge clk_i);
    addr_i = 8'h01; ext_clk_i = 1'b1;
    expect_item(0, 8'h00, "R10 clock 1");
    @(negedge clk_i);
    expect_item(0, 8'h00, "R10 clock 2");
    @(negedge clk_i);
    expect_item(0, 8'h01, "R10 clock 3");
    @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    read_chk(8'h01, 8'h01, "R4 fall not counted");

    // R5 falling edges
    wr(8'h08, 8'h38);
    wr(8'h01, 8'h00);
    pulses(4);
    read_chk(8'h01, 8'h04, "R5 falling edges");
    wr(8'h01, 8'h00);
    @(negedge clk_i); ext_clk_i = 1'b1;
    repeat (5) @(negedge clk_i);
    read_chk(8'h01, 8'h00, "R5 rise not counted");
    @(negedge clk_i); ext_clk_i = 1'b0;
    repeat (5) @(negedge clk_i);
    read_chk(8'h01, 8'h01, "R5 fall counted");

    // R6 prescaler ratios
    wr(8'h08, 8'h00);
    wr(8'h01, 8'h00);
    ticks(9);
    read_chk(8'h01, 8'h04, "R6 ratio 1:2");
    wr(8'h08, 8'h02);
    wr(8'h01, 8'h00);
    ticks(20);
    read_chk(8'h01, 8'h02, "R6 ratio 1:8");

    // R7 count write restarts prescaler
    wr(8'h01, 8'h00);
    ticks(5);
    wr(8'h01, 8'h10);
    ticks(7);
    read_chk(8'h01, 8'h10, "R7 restart hold");
    ticks(1);
    read_chk(8'h01, 8'h11, "R7 restart step");

    // R9 write beats increment
    wr(8'h08, 8'h08);
    @(negedge clk_i);
    cyc_tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 8'h01; wdata_i = 8'h40;
    @(negedge clk_i);
    cyc_tick_i = 1'b0; wr_en_i = 1'b0;
    read_chk(8'h01, 8'h40, "R9 write wins");
    ticks(1);
    read_chk(8'h01, 8'h41, "R9 next tick");

    // R8 sticky overflow
    wr(8'h01, 8'hFE);
    ticks(1);
    ovf_chk(1'b0, "R8 no flag at FF");
    ticks(1);
    read_chk(8'h01, 8'h00, "R8 wrapped");
    ovf_chk(1'b1, "R8 flag set");
    ticks(3);
    read_chk(8'h0B, 8'h01, "R8 flag sticky");
    wr(8'h0B, 8'h00);
    read_chk(8'h0B, 8'h00, "R8 flag cleared");
    ovf_chk(1'b0, "R8 ovf_o cleared");

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule